// File: doc/BRIEF.md
# Seconds Alarm Comparator

This unit stores a 32-bit wake-up time and watches a free-running seconds count from a separate counter block. When the alarm is armed and the count equals the stored time, it latches a pending flag. The flag drives the interrupt line directly, so a consumer that listens for edges sees one clean low-to-high step per alarm.

Software reaches the unit through a byte-wide register port. There are four alarm bytes, an arm/abort control byte, a write-one-to-clear byte and a fixed identity byte. The identity byte lets software tell this unit apart from the counter block. To retire an alarm, software disarms it and then writes the clear bit. When loading a new time, software writes all four bytes first and sets the arm bit last, so a partly written value can never match.

Top module: `salrm_alarm_top`

## Requirements
- R1: The alarm time is held in byte registers at addresses 0x40 (bits 7:0), 0x41 (15:8), 0x42 (23:16) and 0x43 (31:24). Each byte is written by the port and reads back what was written.
- R2: The control byte at address 0x46 holds the arm bit in bit 7 and the abort-enable bit in bit 0. Both read back as written, and the other bits read 0.
- R3: The pending flag goes high at the clock edge where the arm bit is 1 and the seconds count equals the alarm time. It is visible in the cycle after that edge.
- R4: Once set, pending stays high until a write to address 0x48 with bit 0 equal to 1. This holds even if the alarm is disarmed first. After such a clear with no match present, pending is low in the next cycle.
- R5: Address 0x48 always reads 0x00. A write there with bit 0 equal to 0 leaves pending unchanged.
- R6: If a clear write and a live match fall on the same edge, pending stays high.
- R7: The interrupt output equals the pending flag, so it rises from low to high when an alarm fires.
- R8: Address 0x05 reads the identity value 0x03. Unmapped addresses read 0x00.
- R9: The abort-enable bit is only stored. Matches fire the same way whether it is 0 or 1.
- R10: Reset clears the alarm time, both control bits and pending.
- R11: While the arm bit is 0, an equal count never sets pending. This includes an alarm time cleared to zero while the count is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe, one per cycle |
| addr | input | 8 | Register address for read and write |
| wr_data | input | 8 | Register write data |
| rd_data | output | 8 | Combinational read data for addr |
| sec_count | input | 32 | Live seconds count from the counter block |
| irq | output | 1 | Alarm interrupt, high while pending |
| alarm_pending | output | 1 | Latched alarm status |

## Verification
A wrong alarm byte lane or a swapped byte order shows up in two places. It appears on rd_data as soon as the address is presented. It also appears as a missing or unexpected pending flag one edge after the arm bit is set. A pending register that does not hold its value shows up when the bench disarms the alarm or writes a zero clear: the flag drops a cycle later. A clear given wrong priority over a match shows up the cycle after the combined write. Each vector arms the alarm and then checks pending and irq exactly one edge after arming, so a late or missing set is caught within two cycles.

// File: rtl/salrm_pkg.sv
package salrm_pkg;
    // register map (software decodes these addresses)
    localparam int OFF_ID     = 'h05;
    localparam int OFF_ALARM  = 'h40;
    localparam int OFF_CTRL   = 'h46;
    localparam int OFF_CLR    = 'h48;
    localparam int ID_VALUE   = 'h03;
    // bit positions inside the control bytes
    localparam int ARM_BIT    = 7;
    localparam int ABORT_BIT  = 0;
    localparam int CLR_BIT    = 0;
endpackage

// File: rtl/salrm_regs.sv
module salrm_regs
    import salrm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [CNT_W-1:0]  alarm_val,
    output logic              alarm_en,
    output logic              abort_en,
    output logic              clr_hit
);
    localparam int NBYTES = CNT_W / DATA_W;

    typedef struct packed {
        logic [CNT_W-1:0] alarm;
        logic             arm;
        logic             abort;
    } regs_t;

    regs_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (wr_en) begin
            for (int i = 0; i < NBYTES; i++) begin
                if (addr == ADDR_W'(OFF_ALARM + i)) begin
                    st_d.alarm[i*DATA_W +: DATA_W] = wr_data;
                end
            end
            if (addr == ADDR_W'(OFF_CTRL)) begin
                st_d.arm   = wr_data[ARM_BIT];
                st_d.abort = wr_data[ABORT_BIT];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign alarm_val = st_q.alarm;
    assign alarm_en  = st_q.arm;
    assign abort_en  = st_q.abort;
    assign clr_hit   = wr_en && (addr == ADDR_W'(OFF_CLR)) && wr_data[CLR_BIT];
endmodule

// File: rtl/salrm_match.sv
module salrm_match #(
    parameter int CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [CNT_W-1:0] sec_count,
    input  logic [CNT_W-1:0] alarm_val,
    input  logic             alarm_en,
    input  logic             clr_hit,
    output logic             pending
);
    typedef struct packed {
        logic pend;
    } match_t;

    match_t st_d, st_q;
    logic   hit;

    always_comb begin
        hit  = alarm_en && (sec_count == alarm_val);
        st_d = st_q;
        if (clr_hit) begin
            st_d.pend = 1'b0;
        end
        // a live match wins over a clear on the same edge
        if (hit) begin
            st_d.pend = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pending = st_q.pend;
endmodule

// File: rtl/salrm_rdmux.sv
module salrm_rdmux
    import salrm_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [CNT_W-1:0]  alarm_val,
    input  logic              alarm_en,
    input  logic              abort_en,
    output logic [DATA_W-1:0] rd_data
);
    localparam int NBYTES = CNT_W / DATA_W;

    logic [NBYTES-1:0][DATA_W-1:0] lane;

    genvar g;
    generate
        for (g = 0; g < NBYTES; g++) begin : g_lane
            assign lane[g] = (addr == ADDR_W'(OFF_ALARM + g))
                           ? alarm_val[g*DATA_W +: DATA_W] : '0;
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NBYTES; i++) begin
            rd_data = rd_data | lane[i];
        end
        if (addr == ADDR_W'(OFF_CTRL)) begin
            rd_data[ARM_BIT]   = alarm_en;
            rd_data[ABORT_BIT] = abort_en;
        end
        if (addr == ADDR_W'(OFF_ID)) begin
            rd_data = DATA_W'(ID_VALUE);
        end
        // the clear register always reads as zero (default value)
    end
endmodule

// File: rtl/salrm_alarm_top.sv
module salrm_alarm_top #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    input  logic [CNT_W-1:0]  sec_count,
    output logic              irq,
    output logic              alarm_pending
);
    logic [CNT_W-1:0] alarm_val;
    logic             alarm_en;
    logic             abort_en;
    logic             clr_hit;
    logic             pend;

    salrm_regs #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .addr      (addr),
        .wr_data   (wr_data),
        .alarm_val (alarm_val),
        .alarm_en  (alarm_en),
        .abort_en  (abort_en),
        .clr_hit   (clr_hit)
    );

    salrm_match #(.CNT_W(CNT_W)) u_match (
        .clk       (clk),
        .rst_n     (rst_n),
        .sec_count (sec_count),
        .alarm_val (alarm_val),
        .alarm_en  (alarm_en),
        .clr_hit   (clr_hit),
        .pending   (pend)
    );

    salrm_rdmux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_rdmux (
        .addr      (addr),
        .alarm_val (alarm_val),
        .alarm_en  (alarm_en),
        .abort_en  (abort_en),
        .rd_data   (rd_data)
    );

    assign irq           = pend;
    assign alarm_pending = pend;
endmodule

// File: rtl/salrm_checker.sv
module salrm_checker #(
    parameter int ADDR_W = 8,
    parameter int DATA_W = 8,
    parameter int CNT_W  = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] rd_data,
    input logic [CNT_W-1:0]  sec_count,
    input logic [CNT_W-1:0]  alarm_val,
    input logic              alarm_en,
    input logic              clr_hit,
    input logic              irq,
    input logic              alarm_pending
);
    logic live;
    assign live = alarm_en && (sec_count == alarm_val);

    p_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
        live |=> alarm_pending);

    p_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (alarm_pending && !clr_hit) |=> alarm_pending);

    p_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_hit && !live) |=> !alarm_pending);

    p_clr_reads_zero_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h48)) |-> (rd_data == '0));

    p_irq_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> $past(live));

    p_ident_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == ADDR_W'('h05)) |-> (rd_data == DATA_W'('h03)));

    p_no_fire_unarmed_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!alarm_pending && !live) |=> !alarm_pending);
endmodule

bind salrm_alarm_top salrm_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .addr          (addr),
    .rd_data       (rd_data),
    .sec_count     (sec_count),
    .alarm_val     (alarm_val),
    .alarm_en      (alarm_en),
    .clr_hit       (clr_hit),
    .irq           (irq),
    .alarm_pending (alarm_pending)
);

// File: tb/salrm_alarm_top_bench.sv
module salrm_alarm_top_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [7:0]  addr = '0;
    logic [7:0]  wr_data = '0;
    logic [7:0]  rd_data;
    logic [31:0] sec_count = '0;
    logic        irq;
    logic        alarm_pending;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    salrm_alarm_top u_salrm_alarm_top (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .sec_count(sec_count),
        .irq(irq), .alarm_pending(alarm_pending)
    );

    typedef struct packed {
        logic [31:0] alarm;
        logic [31:0] cnt;
        logic        arm;
        logic        abort;
        logic        expect_pend;
    } vec_t;

    localparam int NV = 8;
    localparam vec_t VECS [NV] = '{
        '{32'h12345678, 32'h12345678, 1'b1, 1'b0, 1'b1},
        '{32'h12345678, 32'h12345679, 1'b1, 1'b0, 1'b0},
        '{32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 1'b1, 1'b1},
        '{32'h00000000, 32'h00000000, 1'b1, 1'b0, 1'b1},
        '{32'hA5A5A5A5, 32'hA5A5A5A5, 1'b0, 1'b0, 1'b0},
        '{32'h80000000, 32'h00000080, 1'b1, 1'b0, 1'b0},
        '{32'h00000100, 32'h00000001, 1'b1, 1'b0, 1'b0},
        '{32'hDEADBEEF, 32'hDEADBEEF, 1'b0, 1'b1, 1'b0}
    };

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_chk(input logic [7:0] a, input logic [7:0] exp, input string req);
        addr = a;
        #1;
        check(req, {24'h0, rd_data}, {24'h0, exp});
    endtask

    task automatic load_alarm(input logic [31:0] v);
        for (int b = 0; b < 4; b++) wr(8'h40 + 8'(b), v[b*8 +: 8]);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        check("R10 pending", {31'h0, alarm_pending}, 32'h0);
        for (int b = 0; b < 4; b++) rd_chk(8'h40 + 8'(b), 8'h00, "R10 alarm byte");
        rd_chk(8'h46, 8'h00, "R10 ctrl");
        rd_chk(8'h48, 8'h00, "R5 clear reg reads zero");
        rd_chk(8'h05, 8'h03, "R8 identity");
        rd_chk(8'h07, 8'h00, "R8 unmapped");

        // vector table
        for (int v = 0; v < NV; v++) begin
            load_alarm(VECS[v].alarm);
            sec_count = VECS[v].cnt;
            rd_chk(8'h40, VECS[v].alarm[7:0], "R1 byte0");
            rd_chk(8'h43, VECS[v].alarm[31:24], "R1 byte3");
            wr(8'h46, {VECS[v].arm, 6'b0, VECS[v].abort});
            rd_chk(8'h46, {VECS[v].arm, 6'b0, VECS[v].abort}, "R2 ctrl readback");
            @(negedge clk);
            check("R3/R9/R11 pending", {31'h0, alarm_pending}, {31'h0, VECS[v].expect_pend});
            check("R7 irq", {31'h0, irq}, {31'h0, VECS[v].expect_pend});
            wr(8'h46, 8'h00);
            wr(8'h48, 8'h01);
            @(negedge clk);
            check("R4 cleared", {31'h0, alarm_pending}, 32'h0);
        end

        // R4 sticky after disarm, R5 zero-clear ignored, R7 clean rise
        load_alarm(32'h00000042);
        sec_count = 32'h42;
        check("R7 irq low before", {31'h0, irq}, 32'h0);
        wr(8'h46, 8'h80);
        @(negedge clk);
        check("R7 irq rose", {31'h0, irq}, 32'h1);
        wr(8'h46, 8'h00);
        sec_count = 32'h43;
        repeat (3) @(negedge clk);
        check("R4 sticky after disarm", {31'h0, alarm_pending}, 32'h1);
        wr(8'h48, 8'hFE);
        @(negedge clk);
        check("R5 zero clear ignored", {31'h0, alarm_pending}, 32'h1);
        wr(8'h48, 8'h01);
        check("R4 clear", {31'h0, alarm_pending}, 32'h0);

        // R6 clear on same edge as live match
        sec_count = 32'h42;
        wr(8'h46, 8'h80);
        @(negedge clk);
        check("R6 armed pending", {31'h0, alarm_pending}, 32'h1);
        wr(8'h48, 8'h01);
        check("R6 match beats clear", {31'h0, alarm_pending}, 32'h1);

        // R11 zero alarm, zero count, disarmed
        wr(8'h46, 8'h00);
        load_alarm(32'h0);
        sec_count = 32'h0;
        wr(8'h48, 8'h01);
        repeat (2) @(negedge clk);
        check("R11 unarmed zero", {31'h0, alarm_pending}, 32'h0);

        // R10 mid-run reset
        load_alarm(32'h5A5A5A5A);
        sec_count = 32'h5A5A5A5A;
        wr(8'h46, 8'h81);
        @(negedge clk);
        check("R10 pre-reset pending", {31'h0, alarm_pending}, 32'h1);
        sec_count = 32'h0;
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check("R10 pending cleared", {31'h0, alarm_pending}, 32'h0);
        rd_chk(8'h42, 8'h00, "R10 alarm cleared");
        rd_chk(8'h46, 8'h00, "R10 ctrl cleared");

        done = 1;
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule